// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides an incoming clock by an integer set from a 9-bit main count M and a 4-bit swallow count A. It builds the ratio with a divide-by-10/11 prescaler that feeds a main counter, while a swallow counter chooses the prescaler modulus. Each output period holds M+1 prescaler cycles. The first A of them are eleven input cycles long and the rest are ten, which gives a total of 10·(M+1)+A input cycles. The input clock is the logic clock itself, so one input cycle is one `clk` cycle.

An active-low prescaler enable is provided. Driving it high bypasses the prescaler and ignores A, so the chain divides by M+1. A direct-programming flag clears the two upper bits of M, which limits M to 1..127. The block emits a one-cycle output pulse per division period. It also gives registered copies of the modulus-select signal and of the raw prescaler pulse, so that either one can be routed to a shared debug pin without glitches. M, A and the mode inputs are sampled only at a period boundary, so a change never shortens or stretches a period that is already running.

Top module: `pswallow_divider`

## Requirements
- R1: While rst_n is low, fp_pulse, msel_mon and presc_mon are all 0.
- R2: With presc_en_n=0 and direct_mode=0, the number of clk cycles from one fp_pulse rise to the next is 10·(M+1)+A, for 1 ≤ M ≤ 511 and A ≤ M+1.
- R3: The prescaler divides by 11 for the first A prescaler cycles of each period and by 10 for the rest. msel_mon is therefore high for exactly 11·A clk cycles in every output period.
- R4: With presc_en_n=1, the period is M+1 clk cycles whatever the value of A, and msel_mon stays 0.
- R5: With direct_mode=1, bits 8 and 7 of m_val are treated as 0 and only m_val[6:0] sets M.
- R6: The smallest M of 1 gives a period of 20+A with the prescaler on and a period of 2 in bypass.
- R7: m_val, a_val, presc_en_n and direct_mode are captured only at a period boundary. A change in the middle of a period leaves the length of that period unchanged, and the new length applies from the next period.
- R8: fp_pulse is high for exactly one clk cycle per period.
- R9: presc_mon pulses once at the end of each prescaler cycle, which gives M+1 pulses per output period. In bypass it is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided; also the logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_val | input | 9 | Main count M |
| a_val | input | 4 | Swallow count A |
| presc_en_n | input | 1 | Prescaler enable, active low; high selects bypass |
| direct_mode | input | 1 | Clears M bits 8:7 when high |
| fp_pulse | output | 1 | One-cycle pulse per division period |
| msel_mon | output | 1 | Registered modulus select (1 = divide by 11) |
| presc_mon | output | 1 | Registered prescaler terminal pulse |

## Verification
The bench targets the edges of the swallow range. A=0 must leave every prescaler cycle at ten, and A=M+1 must make every cycle eleven. A swallow counter that is off by one would add or drop eleven cycles, or would leave msel stuck high across a boundary. It also checks the smallest M in both modes, where a counter that ends one step late would give periods of 30 or 3. A configuration change in the middle of a period must not alter the current length; a design that reloads early would produce one short or long period. Finally, direct mode with bits 8:7 set separates a correct mask from one that lets the upper bits through, which would give a period several hundred cycles too long.

// File: rtl/pswd_pkg.sv
package pswd_pkg;

    // Prescaler modulus currently selected
    typedef enum logic {
        MOD_BASE = 1'b0,
        MOD_PLUS = 1'b1
    } mod_sel_e;

    // Registered outputs of the top level
    typedef struct packed {
        logic     fp;
        mod_sel_e msel;
        logic     pout;
    } mon_t;

endpackage

// File: rtl/pswd_prescaler.sv
module pswd_prescaler #(
    parameter int PRE_BASE = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic bypass,
    input  logic mod_plus,
    output logic pre_end
);
    localparam int CW = $clog2(PRE_BASE + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [CW-1:0] last_cnt;

    always_comb begin
        st_d     = st_q;
        last_cnt = mod_plus ? CW'(PRE_BASE) : CW'(PRE_BASE - 1);
        pre_end  = run & (bypass | (st_q.cnt == last_cnt));
        if (!run || bypass || pre_end)
            st_d.cnt = '0;
        else
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the counter never passes the divide-by-11 terminal value
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(PRE_BASE));

    // R4: the prescaler counter stays idle while bypassed
    a_r4_bypass_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bypass) |=> (st_q.cnt == '0));

endmodule

// File: rtl/pswd_swallow.sv
module pswd_swallow #(
    parameter int M_W  = 9,
    parameter int A_W  = 4,
    parameter int MD_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [M_W-1:0] m_in,
    input  logic [A_W-1:0] a_in,
    input  logic           bypass_in,
    input  logic           direct_in,
    input  logic           pre_end,
    output logic           run,
    output logic           bypass,
    output logic           mod_plus,
    output logic           period_end
);
    localparam logic [M_W-1:0] DIRECT_MASK = M_W'((1 << MD_W) - 1);

    typedef struct packed {
        logic           run;
        logic           byp;
        logic [M_W-1:0] m;
        logic [A_W-1:0] a;
        logic [M_W-1:0] mc;
        logic [A_W-1:0] ac;
    } sw_st_t;

    sw_st_t st_d, st_q;
    logic [M_W-1:0] m_eff;
    logic [A_W-1:0] a_eff;

    always_comb begin
        st_d       = st_q;
        m_eff      = direct_in ? (m_in & DIRECT_MASK) : m_in;
        a_eff      = bypass_in ? '0 : a_in;
        mod_plus   = st_q.run & ~st_q.byp & (st_q.ac != '0);
        period_end = st_q.run & pre_end & (st_q.mc == st_q.m);

        if (!st_q.run || period_end) begin
            st_d.run = 1'b1;
            st_d.byp = bypass_in;
            st_d.m   = m_eff;
            st_d.a   = a_eff;
            st_d.mc  = '0;
            st_d.ac  = a_eff;
        end else if (pre_end) begin
            st_d.mc = st_q.mc + 1'b1;
            if (st_q.ac != '0)
                st_d.ac = st_q.ac - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run    = st_q.run;
    assign bypass = st_q.byp;

    // R7: captured settings hold for the whole period
    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !period_end) |=> ($stable(st_q.m) && $stable(st_q.a) && $stable(st_q.byp)));

    // R2: main count never runs past the captured M
    a_r2_mc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.mc <= st_q.m));

    // R3: swallow count never exceeds the captured A
    a_r3_ac_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ac <= st_q.a);

    // R4: no swallowing in bypass
    a_r4_no_swallow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.byp |-> (st_q.ac == '0));

endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider
    import pswd_pkg::*;
#(
    parameter int M_W      = 9,
    parameter int A_W      = 4,
    parameter int MD_W     = 7,
    parameter int PRE_BASE = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [M_W-1:0] m_val,
    input  logic [A_W-1:0] a_val,
    input  logic           presc_en_n,
    input  logic           direct_mode,
    output logic           fp_pulse,
    output logic           msel_mon,
    output logic           presc_mon
);
    logic run_w, byp_w, mod_plus_w, pre_end_w, period_end_w;

    pswd_prescaler #(.PRE_BASE(PRE_BASE)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_w),
        .bypass   (byp_w),
        .mod_plus (mod_plus_w),
        .pre_end  (pre_end_w)
    );

    pswd_swallow #(.M_W(M_W), .A_W(A_W), .MD_W(MD_W)) u_sw (
        .clk        (clk),
        .rst_n      (rst_n),
        .m_in       (m_val),
        .a_in       (a_val),
        .bypass_in  (presc_en_n),
        .direct_in  (direct_mode),
        .pre_end    (pre_end_w),
        .run        (run_w),
        .bypass     (byp_w),
        .mod_plus   (mod_plus_w),
        .period_end (period_end_w)
    );

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d      = mon_q;
        mon_d.fp   = period_end_w;
        mon_d.msel = mod_plus_w ? MOD_PLUS : MOD_BASE;
        mon_d.pout = pre_end_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end

    assign fp_pulse  = mon_q.fp;
    assign msel_mon  = (mon_q.msel == MOD_PLUS);
    assign presc_mon = mon_q.pout;

    // R8: the output pulse is one cycle wide
    a_r8_fp_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        fp_pulse |=> !fp_pulse);

    // R9: every period end is also a prescaler cycle end
    a_r9_fp_with_pout: assert property (@(posedge clk) disable iff (!rst_n)
        fp_pulse |-> presc_mon);

    // R4: bypass keeps modulus select low
    a_r4_msel_low: assert property (@(posedge clk) disable iff (!rst_n)
        byp_w |=> !msel_mon);

endmodule

// File: tb/sim_pswallow_divider.sv
`timescale 1ns/1ps
module sim_pswallow_divider;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [8:0] m_val;
    logic [3:0] a_val;
    logic       presc_en_n, direct_mode;
    logic       fp_pulse, msel_mon, presc_mon;

    always #2.5 clk = ~clk;

    pswallow_divider u0 (
        .clk(clk), .rst_n(rst_n), .m_val(m_val), .a_val(a_val),
        .presc_en_n(presc_en_n), .direct_mode(direct_mode),
        .fp_pulse(fp_pulse), .msel_mon(msel_mon), .presc_mon(presc_mon)
    );

    typedef struct packed {
        logic [8:0]  m;
        logic [3:0]  a;
        logic        byp;
        logic        dir;
        int unsigned per;
        int unsigned ms;
        int unsigned po;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{9'd5,   4'd3,  1'b0, 1'b0, 63,   33,  6},
        '{9'd1,   4'd0,  1'b0, 1'b0, 20,   0,   2},
        '{9'd1,   4'd2,  1'b0, 1'b0, 22,   22,  2},
        '{9'd300, 4'd15, 1'b0, 1'b0, 3025, 165, 301},
        '{9'd20,  4'd7,  1'b1, 1'b0, 21,   0,   21},
        '{9'd1,   4'd9,  1'b1, 1'b0, 2,    0,   2},
        '{9'h1C5, 4'd4,  1'b0, 1'b1, 704,  44,  70},
        '{9'd9,   4'd10, 1'b0, 1'b0, 110,  110, 10},
        '{9'h183, 4'd5,  1'b1, 1'b1, 4,    0,   4},
        '{9'd511, 4'd0,  1'b0, 1'b0, 5120, 0,   512}
    };

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [8:0] m, input logic [3:0] a,
                           input logic byp, input logic dir);
        m_val = m; a_val = a; presc_en_n = byp; direct_mode = dir;
    endtask

    task automatic wait_fp();
        bit seen = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (fp_pulse) begin seen = 1; break; end
        end
        if (!seen) chk("R2 no output pulse", 0, 1);
    endtask

    // Called at a negedge where fp_pulse is high; ends at the next one
    task automatic measure(output int per, output int ms, output int po);
        per = 1; ms = int'(msel_mon); po = int'(presc_mon);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (fp_pulse) break;
            per++; ms += int'(msel_mon); po += int'(presc_mon);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int per, ms, po;
        string rq;
        rst_n = 1'b0;
        set_cfg(9'd5, 4'd3, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R1 fp in reset",   int'(fp_pulse),  0);
        chk("R1 msel in reset", int'(msel_mon),  0);
        chk("R1 pout in reset", int'(presc_mon), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            set_cfg(VECS[i].m, VECS[i].a, VECS[i].byp, VECS[i].dir);
            wait_fp();
            wait_fp();
            measure(per, ms, po);
            if (VECS[i].m == 9'd1)  rq = "R6 period";
            else if (VECS[i].dir)   rq = "R5 period";
            else if (VECS[i].byp)   rq = "R4 period";
            else                    rq = "R2 period";
            chk(rq, per, int'(VECS[i].per));
            chk("R3 msel cycles", ms, int'(VECS[i].ms));
            chk("R9 pout pulses", po, int'(VECS[i].po));
        end

        // R7: change settings mid-period
        set_cfg(9'd5, 4'd3, 1'b0, 1'b0);
        wait_fp();
        wait_fp();
        per = 1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            per++;
        end
        set_cfg(9'd2, 4'd1, 1'b0, 1'b0);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (fp_pulse) break;
            per++;
        end
        chk("R7 current period kept", per, 63);
        measure(per, ms, po);
        chk("R7 new period applied", per, 31);

        // R8: pulse width at the shortest period
        set_cfg(9'd1, 4'd0, 1'b1, 1'b0);
        wait_fp();
        wait_fp();
        @(negedge clk);
        chk("R8 fp low after pulse", int'(fp_pulse), 0);
        @(negedge clk);
        chk("R8 fp high next period", int'(fp_pulse), 1);

        // R8: single-cycle pulse with a long period
        set_cfg(9'd3, 4'd2, 1'b0, 1'b0);
        wait_fp();
        wait_fp();
        @(negedge clk);
        chk("R8 fp one cycle wide", int'(fp_pulse), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule